// File: doc/BRIEF.md
# Immediate-Operand Data-Processing Execution Unit

This block carries out the immediate-operand data-processing class of a 64-bit load/store instruction subset. It takes one 32-bit instruction word of that class, the value of the source register and the current value of the destination register, and produces the value to write back, a write enable, a destination index and the four condition flags with their own update enable. Two groups of operation are covered. The first is add or subtract of a 12-bit immediate that can be pre-shifted left by 12, with or without a flag update. The second is the wide move family, which places a 16-bit immediate into one 16-bit lane of the register: inverted, zero-filled, or merged into the old register contents.

A width bit chooses 32-bit or 64-bit operation. In 32-bit mode only the low half of each operand counts, and every result has its upper half forced to zero. The computation is combinational. Its outputs are captured in a single register stage, so a result appears on the clock edge after its issue. The register file, the fetch logic and the class decoder that steers words to this unit are not part of the block.

Top module: `imm_dp_unit`

## Requirements
- R1: Bit 31 of `instr` is the width bit (1 = 64-bit, 0 = 32-bit). In 32-bit mode only bits 31:0 of `src_val` and `dst_old` are used, and `res_data[63:32]` is zero.
- R2: Bits 25:23 of `instr` choose the group: 2 is add/subtract immediate and 5 is wide move. Any other value raises `res_err` with `res_we`, `flg_we`, `res_data` and `flg_nzcv` all zero.
- R3: For add/subtract, bits 30:29 select ADD=0, ADDS=1, SUB=2, SUBS=3. The operand is the 12-bit field at bits 21:10, shifted left by 12 when bit 22 is 1. The result is `src_val` plus or minus that operand.
- R4: `flg_we` is 1 only for ADDS and SUBS, and `flg_nzcv` is {N,Z,C,V} (bit 3 = N, bit 0 = V). N is the top bit of the result at the active width, and Z is 1 when the result is zero.
- R5: For ADDS, C is the unsigned carry out of the active width. V is 1 when both operands have the same sign and the sign of the result differs from it.
- R6: For SUBS, C is 1 when the minuend is unsigned greater than or equal to the subtrahend. V is 1 when the operand signs differ and the sign of the result differs from the minuend.
- R7: For wide move, the 16-bit immediate is at bits 20:5 and the lane selector at bits 22:21 places it at bit 16 × lane. Opcode 2 (move-zero) writes the placed immediate with all other bits zero. Opcode 0 (move-not) writes the bitwise inverse of the placed immediate, truncated to the width.
- R8: Wide move with opcode 3 (move-keep) writes `dst_old` with only the selected lane replaced by the immediate.
- R9: A wide move with opcode 1, or a 32-bit wide move with a lane selector above 1, raises `res_err` and suppresses the write.
- R10: A destination index (bits 4:0) of 31 clears `res_we`. An ADDS or SUBS to index 31 still updates the flags. `res_dst` always shows bits 4:0.
- R11: Outputs are registered: `res_vld` follows `issue_vld` one cycle later, with the result of that issue. In a cycle after no issue, every enable, `res_err`, `res_data` and `flg_nzcv` are zero.
- R12: While `rst_n` is low at a rising clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_vld | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word of the immediate data-processing class |
| src_val | input | 64 | Value of the source register (add/subtract) |
| dst_old | input | 64 | Current value of the destination register (move-keep) |
| res_vld | output | 1 | A result from the previous cycle's issue is present |
| res_we | output | 1 | Write `res_data` to register `res_dst` |
| res_dst | output | 5 | Destination register index |
| res_data | output | 64 | Result value |
| res_err | output | 1 | Illegal encoding was issued |
| flg_we | output | 1 | Update the condition flags |
| flg_nzcv | output | 4 | New flags {N,Z,C,V} |

## Verification
The bound checker watches properties that hold every cycle. Enables follow an issue and never appear on an error. A destination index of 31 never writes. Flag updates come only from flag-setting add or subtract. A 32-bit write has a zero upper half, and the Z flag agrees with a zero result. The exact values need the bench's scenarios, which compare against a model built from the requirements. These cover carry and overflow at both widths with upper-half garbage on the operands, lane placement and inversion, move-keep merging, and each illegal combination.

// File: rtl/imm_dp_pkg.sv
// Shared encodings for the immediate data-processing unit.
// Assumes the 32-bit instruction layout described in the brief.
package imm_dp_pkg;

    // Field positions inside the instruction word
    localparam int INSN_W     = 32;
    localparam int F_WIDE     = 31;
    localparam int F_OPC_LO   = 29;
    localparam int F_GRP_LO   = 23;
    localparam int F_ASHIFT   = 22;
    localparam int F_AIMM_LO  = 10;
    localparam int F_LANE_LO  = 21;
    localparam int F_WIMM_LO  = 5;
    localparam int F_RD_LO    = 0;
    localparam int AIMM_W     = 12;
    localparam int ASHIFT_AMT = 12;
    localparam int GRP_W      = 3;
    localparam int OPC_W      = 2;
    localparam int RIDX_W     = 5;
    localparam int LSEL_W     = 2;

    // Group selector values
    localparam logic [GRP_W-1:0] GRP_ARITH = 3'd2;
    localparam logic [GRP_W-1:0] GRP_WMOVE = 3'd5;

    // Wide move opcodes
    localparam logic [OPC_W-1:0] WMV_NOT  = 2'd0;
    localparam logic [OPC_W-1:0] WMV_BAD  = 2'd1;
    localparam logic [OPC_W-1:0] WMV_ZERO = 2'd2;
    localparam logic [OPC_W-1:0] WMV_KEEP = 2'd3;

    // Register index that discards writes
    localparam logic [RIDX_W-1:0] DISCARD_IDX = 5'd31;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/imm_dp_arith.sv
// Adder/subtractor for the immediate group with flag generation.
// Subtraction reuses the adder with an inverted operand and carry-in of one.
// Assumes DATA_W is even; the narrow mode uses the low DATA_W/2 bits.
module imm_dp_arith
    import imm_dp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              is_wide,
    input  logic              do_sub,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] sum_o,
    output nzcv_t             flags_o
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_m;
    logic [DATA_W:0]   total;
    logic              sa, sb, sr;

    // Mask operands to the active width and form the extended sum
    always_comb begin
        mask  = is_wide ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
        a_m   = op_a & mask;
        b_m   = (do_sub ? ~op_b : op_b) & mask;
        total = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, do_sub};
        sum_o = total[DATA_W-1:0] & mask;
    end

    // Derive the condition flags from the active-width sign bits
    always_comb begin
        sa        = is_wide ? a_m[DATA_W-1]   : a_m[HALF-1];
        sb        = is_wide ? b_m[DATA_W-1]   : b_m[HALF-1];
        sr        = is_wide ? sum_o[DATA_W-1] : sum_o[HALF-1];
        flags_o.n = sr;
        flags_o.z = (sum_o == '0);
        flags_o.c = is_wide ? total[DATA_W] : total[HALF];
        flags_o.v = (sa == sb) && (sr != sa);
    end

endmodule

// File: rtl/imm_dp_widemove.sv
// Lane placement for the wide move group: zero-fill, inverse and keep.
// One slice per lane is generated; the lane selector picks the slice
// that takes the immediate. Flags illegal opcode or narrow-mode lane.
module imm_dp_widemove
    import imm_dp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic                              is_wide,
    input  logic [OPC_W-1:0]                  opc,
    input  logic [$clog2(DATA_W/LANE_W)-1:0]  lane_sel,
    input  logic [LANE_W-1:0]                 imm,
    input  logic [DATA_W-1:0]                 old_val,
    output logic [DATA_W-1:0]                 result,
    output logic                              bad
);
    localparam int NLANE = DATA_W / LANE_W;
    localparam int SEL_W = $clog2(NLANE);
    localparam int HALF  = DATA_W / 2;

    logic [DATA_W-1:0] raw;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic              hit;
        logic [LANE_W-1:0] lane_v;
        assign hit = (lane_sel == SEL_W'(g));
        // Choose this lane's contents for the requested variant
        always_comb begin
            case (opc)
                WMV_KEEP: lane_v = hit ? imm  : old_val[g*LANE_W +: LANE_W];
                WMV_NOT:  lane_v = hit ? ~imm : {LANE_W{1'b1}};
                default:  lane_v = hit ? imm  : {LANE_W{1'b0}};
            endcase
        end
        assign raw[g*LANE_W +: LANE_W] = lane_v;
    end

    // Truncate to the active width and flag illegal forms
    always_comb begin
        result = is_wide ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
        bad    = (opc == WMV_BAD) || (!is_wide && (int'(lane_sel) >= NLANE / 2));
    end

endmodule

// File: rtl/imm_dp_unit.sv
// Immediate data-processing execution unit (top).
// Splits the instruction word into fields, runs the add/subtract and
// wide move datapaths in parallel, selects by group and registers the
// outcome for one cycle. Assumes the word already belongs to this class.
module imm_dp_unit
    import imm_dp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] dst_old,
    output logic              res_vld,
    output logic              res_we,
    output logic [4:0]        res_dst,
    output logic [DATA_W-1:0] res_data,
    output logic              res_err,
    output logic              flg_we,
    output logic [3:0]        flg_nzcv
);
    localparam int SEL_W = $clog2(DATA_W / LANE_W);

    logic              is_wide;
    logic [GRP_W-1:0]  grp;
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] rd;
    logic [DATA_W-1:0] ar_b;
    logic [DATA_W-1:0] ar_sum;
    nzcv_t             ar_flags;
    logic [DATA_W-1:0] wm_res;
    logic              wm_bad;
    logic              is_ar, is_wm;
    logic              nxt_err, nxt_we, nxt_fwe;
    logic [DATA_W-1:0] nxt_data;
    logic [3:0]        nxt_nzcv;

    // Extract the instruction fields and the shifted arithmetic operand
    always_comb begin
        is_wide = instr[F_WIDE];
        grp     = instr[F_GRP_LO +: GRP_W];
        opc     = instr[F_OPC_LO +: OPC_W];
        rd      = instr[F_RD_LO +: RIDX_W];
        ar_b    = DATA_W'(instr[F_AIMM_LO +: AIMM_W]);
        if (instr[F_ASHIFT]) begin
            ar_b = ar_b << ASHIFT_AMT;
        end
    end

    imm_dp_arith #(
        .DATA_W (DATA_W)
    ) u_arith (
        .is_wide (is_wide),
        .do_sub  (opc[1]),
        .op_a    (src_val),
        .op_b    (ar_b),
        .sum_o   (ar_sum),
        .flags_o (ar_flags)
    );

    imm_dp_widemove #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_wmove (
        .is_wide  (is_wide),
        .opc      (opc),
        .lane_sel (instr[F_LANE_LO +: SEL_W]),
        .imm      (instr[F_WIMM_LO +: LANE_W]),
        .old_val  (dst_old),
        .result   (wm_res),
        .bad      (wm_bad)
    );

    // Select the group result and form the enables
    always_comb begin
        is_ar    = (grp == GRP_ARITH);
        is_wm    = (grp == GRP_WMOVE);
        nxt_err  = !(is_ar || is_wm) || (is_wm && wm_bad);
        nxt_data = nxt_err ? '0 : (is_ar ? ar_sum : wm_res);
        nxt_we   = !nxt_err && (rd != DISCARD_IDX);
        nxt_fwe  = is_ar && opc[0];
        nxt_nzcv = nxt_fwe ? ar_flags : 4'b0000;
    end

    // Output register stage, cleared on reset and on idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_we   <= 1'b0;
            res_dst  <= '0;
            res_data <= '0;
            res_err  <= 1'b0;
            flg_we   <= 1'b0;
            flg_nzcv <= '0;
        end else begin
            res_vld <= issue_vld;
            if (issue_vld) begin
                res_we   <= nxt_we;
                res_dst  <= rd;
                res_data <= nxt_data;
                res_err  <= nxt_err;
                flg_we   <= nxt_fwe;
                flg_nzcv <= nxt_nzcv;
            end else begin
                res_we   <= 1'b0;
                res_dst  <= '0;
                res_data <= '0;
                res_err  <= 1'b0;
                flg_we   <= 1'b0;
                flg_nzcv <= '0;
            end
        end
    end

endmodule

// File: rtl/imm_dp_unit_chk.sv
// Property checker for imm_dp_unit, attached through bind below.
// Observes only the top-level ports of the unit.
module imm_dp_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_vld,
    input logic [31:0] instr,
    input logic        res_vld,
    input logic        res_we,
    input logic [4:0]  res_dst,
    input logic [63:0] res_data,
    input logic        res_err,
    input logic        flg_we,
    input logic [3:0]  flg_nzcv
);

    AST_VLD_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |=> res_vld); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> !res_we && !flg_we && !res_err); // R11

    AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> !res_we && !flg_we); // R2

    AST_DISCARD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_dst == 5'd31) |-> !res_we); // R10

    AST_FLAGS_ONLY_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
        flg_we |-> ($past(instr[25:23]) == 3'd2) && $past(instr[29])); // R4

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && !$past(instr[31])) |-> (res_data[63:32] == 32'h0)); // R1

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        flg_we |-> (flg_nzcv[2] == (res_data == 64'h0))); // R4

endmodule

bind imm_dp_unit imm_dp_unit_chk u_chk (.*);

// File: tb/imm_dp_unit_tb.sv
// Scoreboard bench: a driver task issues words and queues expected
// results from a requirement-level model; a monitor pops and compares.
module imm_dp_unit_tb;

    typedef struct {
        logic [63:0] data;
        logic        we;
        logic        fwe;
        logic        err;
        logic [3:0]  nzcv;
        logic [4:0]  dst;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_vld;
    logic [31:0] instr;
    logic [63:0] src_val;
    logic [63:0] dst_old;
    logic        res_vld, res_we, res_err, flg_we;
    logic [4:0]  res_dst;
    logic [63:0] res_data;
    logic [3:0]  flg_nzcv;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    imm_dp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .instr(instr),
        .src_val(src_val), .dst_old(dst_old), .res_vld(res_vld),
        .res_we(res_we), .res_dst(res_dst), .res_data(res_data),
        .res_err(res_err), .flg_we(flg_we), .flg_nzcv(flg_nzcv)
    );

    function automatic logic [31:0] enc_ar(logic sf, logic [1:0] op, logic sh,
                                           logic [11:0] imm, logic [4:0] rn, logic [4:0] rd);
        return {sf, op, 3'b100, 3'd2, sh, imm, rn, rd};
    endfunction

    function automatic logic [31:0] enc_wm(logic sf, logic [1:0] op, logic [1:0] hw,
                                           logic [15:0] imm, logic [4:0] rd);
        return {sf, op, 3'b100, 3'd5, hw, imm, rd};
    endfunction

    // Expected outcome written from the requirements
    function automatic exp_t model(logic [31:0] ins, logic [63:0] src, logic [63:0] old);
        exp_t        e;
        int          wid;
        logic [63:0] msk, a, b, r, placed, lmask;
        logic [64:0] wsum;
        logic        c, v, sa, sb, sr, sub;
        int          pos;
        wid    = ins[31] ? 64 : 32;
        msk    = ins[31] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        e.dst  = ins[4:0];
        e.data = '0; e.we = 0; e.fwe = 0; e.err = 0; e.nzcv = '0;
        if (ins[25:23] == 3'd2) begin
            a   = src & msk;
            b   = {52'b0, ins[21:10]};
            if (ins[22]) b = b << 12;
            sub = ins[30];
            if (!sub) begin
                wsum = {1'b0, a} + {1'b0, b};
                r    = wsum[63:0] & msk;
                c    = ins[31] ? wsum[64] : wsum[32];
            end else begin
                r = (a - b) & msk;
                c = (a >= b);
            end
            sa = a[wid-1]; sb = b[wid-1]; sr = r[wid-1];
            v  = sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
            e.data = r;
            e.we   = (ins[4:0] != 5'd31);
            e.fwe  = ins[29];
            if (e.fwe) e.nzcv = {sr, (r == 64'h0), c, v};
        end else if (ins[25:23] == 3'd5) begin
            if (ins[30:29] == 2'd1 || (!ins[31] && ins[22:21] > 2'd1)) begin
                e.err = 1;
            end else begin
                pos    = 16 * int'(ins[22:21]);
                lmask  = 64'hFFFF << pos;
                placed = {48'b0, ins[20:5]} << pos;
                case (ins[30:29])
                    2'd2:    r = placed;
                    2'd0:    r = ~placed;
                    default: r = (old & ~lmask) | placed;
                endcase
                e.data = r & msk;
                e.we   = (ins[4:0] != 5'd31);
            end
        end else begin
            e.err = 1;
        end
        return e;
    endfunction

    task automatic send(logic [31:0] ins, logic [63:0] src, logic [63:0] old, string tag);
        exp_t e;
        @(negedge clk);
        instr     = ins;
        src_val   = src;
        dst_old   = old;
        issue_vld = 1'b1;
        e         = model(ins, src, old);
        e.tag     = tag;
        sb_q.push_back(e);
    endtask

    task automatic go_idle();
        @(negedge clk);
        issue_vld = 1'b0;
        instr     = 32'h0;
    endtask

    // Monitor: compare each result against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && res_vld) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11: unexpected result data=%h expected none", res_data);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (res_data !== e.data || res_we !== e.we || flg_we !== e.fwe ||
                    res_err !== e.err || flg_nzcv !== e.nzcv || res_dst !== e.dst) begin
                    n_fail++;
                    $display("FAIL %s: got data=%h we=%b fwe=%b err=%b nzcv=%b dst=%0d exp data=%h we=%b fwe=%b err=%b nzcv=%b dst=%0d",
                             e.tag, res_data, res_we, flg_we, res_err, flg_nzcv, res_dst,
                             e.data, e.we, e.fwe, e.err, e.nzcv, e.dst);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; issue_vld = 1'b0; instr = '0; src_val = '0; dst_old = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if ({res_vld, res_we, res_err, flg_we, flg_nzcv, res_dst} !== '0 || res_data !== '0) begin
            n_fail++;
            $display("FAIL R12: outputs after reset vld=%b data=%h expected all zero", res_vld, res_data);
        end
        rst_n = 1'b1;

        send(enc_ar(1, 2'd0, 0, 12'd5,    5'd1, 5'd2), 64'h10, 64'h0, "R3 add x");
        send(enc_ar(1, 2'd0, 1, 12'd1,    5'd1, 5'd3), 64'h22, 64'h0, "R3 add shifted");
        send(enc_ar(0, 2'd2, 0, 12'h123,  5'd1, 5'd4), 64'hDEAD_BEEF_0000_1000, 64'h0, "R1 sub w ignores upper");
        send(enc_ar(1, 2'd1, 0, 12'd1,    5'd1, 5'd5), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R5 adds x carry");
        send(enc_ar(1, 2'd1, 0, 12'd1,    5'd1, 5'd5), 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, "R5 adds x overflow");
        send(enc_ar(0, 2'd1, 0, 12'd1,    5'd1, 5'd5), 64'h0000_0001_FFFF_FFFF, 64'h0, "R5 adds w carry");
        send(enc_ar(0, 2'd1, 0, 12'd1,    5'd1, 5'd5), 64'h0000_0000_7FFF_FFFF, 64'h0, "R5 adds w overflow");
        send(enc_ar(0, 2'd3, 0, 12'd7,    5'd1, 5'd6), 64'h5, 64'h0, "R6 subs w borrow");
        send(enc_ar(1, 2'd3, 0, 12'd7,    5'd1, 5'd6), 64'h7, 64'h0, "R6 subs x equal");
        send(enc_ar(1, 2'd3, 0, 12'd1,    5'd1, 5'd6), 64'h8000_0000_0000_0000, 64'h0, "R6 subs x overflow");
        send(enc_ar(1, 2'd3, 1, 12'd1,    5'd1, 5'd31), 64'h1000, 64'h0, "R10 subs to discard index");
        send(enc_wm(1, 2'd2, 2'd3, 16'hABCD, 5'd7), 64'h0, 64'hFFFF, "R7 movz x lane3");
        send(enc_wm(0, 2'd0, 2'd1, 16'h1234, 5'd7), 64'h0, 64'h0, "R7 movn w lane1");
        send(enc_wm(1, 2'd0, 2'd0, 16'h00FF, 5'd7), 64'h0, 64'h0, "R7 movn x lane0");
        send(enc_wm(1, 2'd3, 2'd2, 16'hBEEF, 5'd8), 64'h0, 64'h1111_2222_3333_4444, "R8 movk x lane2");
        send(enc_wm(0, 2'd3, 2'd0, 16'hBEEF, 5'd8), 64'h0, 64'hAAAA_BBBB_CCCC_DDDD, "R8 movk w lane0");
        send(enc_wm(0, 2'd2, 2'd2, 16'h5555, 5'd9), 64'h0, 64'h0, "R9 narrow lane2");
        send(enc_wm(1, 2'd1, 2'd0, 16'h5555, 5'd9), 64'h0, 64'h0, "R9 opcode one");
        send(enc_wm(1, 2'd2, 2'd1, 16'h5555, 5'd31), 64'h0, 64'h0, "R10 movz discard");
        send({1'b1, 2'd1, 3'b100, 3'd3, 23'h12345}, 64'h5, 64'h0, "R2 bad group 3");
        send({1'b1, 2'd0, 3'b100, 3'd0, 23'h00001}, 64'h5, 64'h0, "R2 bad group 0");
        send(enc_ar(1, 2'd2, 0, 12'hFFF, 5'd1, 5'd2), 64'h1000, 64'h0, "R3 sub x");
        go_idle();
        @(negedge clk);
        @(negedge clk);
        n_checks++;
        if (res_vld !== 1'b0 || res_we !== 1'b0 || flg_we !== 1'b0 || res_data !== '0) begin
            n_fail++;
            $display("FAIL R11: idle vld=%b we=%b fwe=%b data=%h expected 0 0 0 0",
                     res_vld, res_we, flg_we, res_data);
        end
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11: %0d results missing, expected 0", sb_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule